// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a synchronous host port to an external asynchronous static RAM with 16-bit words and two byte lanes. The host offers one request at a time with a valid/ready handshake: a word address, write data, a write flag and a byte mask. Reads return data with a one-cycle valid strobe. The controller drives the memory's active-low chip select, write enable, output enable and per-lane enables. The data bus is driven through a separate output value and tri-state enable, and read data comes back on its own input.

After reset a power-up counter holds the host off until the memory's start-up interval has passed. Read and write pulse lengths are counted in clock cycles and set by parameters, so the same RTL can serve any clock rate. Output enable stays high for the whole of a write. The data bus is driven only while write enable is low. A turnaround cycle follows every write, so the bus is released before a read can start.

The sequencer has five states. INIT waits for the power-up counter. IDLE accepts requests. READ holds a read strobe. WRITE holds the write pulse. TURN releases the bus after a write. The transitions are:
- INIT to IDLE when the power-up count expires.
- IDLE to READ or WRITE on an accepted request whose mask is not zero.
- READ to IDLE when the read timer expires.
- WRITE to TURN when the write timer expires.
- TURN to IDLE after one cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, req_ready stays low for exactly PWRUP_CYCLES+1 clock edges and rises at the following sample. During that time every memory strobe is high and the bus is released.
- R2: Whenever sram_cs_n is high, sram_we_n and sram_oe_n are high and sram_dq_oe is low.
- R3: A read holds sram_cs_n low, sram_we_n high and sram_oe_n low for RD_CYCLES cycles, with sram_addr equal to the request address. rsp_valid is high in the following cycle, together with the read data.
- R4: Lane bit 0 covers data bits 7:0 and lane bit 1 covers bits 15:8. During an access sram_lane_n[i] is low exactly when req_mask[i] was 1. rsp_rdata bits of unselected lanes are zero.
- R5: A write holds sram_cs_n low, sram_we_n low and sram_dq_oe high for WR_CYCLES cycles, with sram_dq_out equal to the request write data.
- R6: A masked write changes only the selected byte lane in memory. A later full read returns the old value of the other lane.
- R7: After the write pulse there is one cycle with sram_we_n high, sram_dq_oe low, sram_cs_n high, the address unchanged and req_ready low.
- R8: sram_oe_n is never low while sram_we_n is low or sram_dq_oe is high.
- R9: A request with mask 2'b00 asserts no strobe and req_ready stays high. A read of this kind gives rsp_valid in the next cycle with rsp_rdata zero. A write of this kind leaves memory unchanged.
- R10: After a request with a non-zero mask is accepted, req_ready is low in the next cycle and stays low until the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mask | input | DATA_W/LANE_W | Byte lanes to access, bit 0 = low byte |
| rsp_valid | output | 1 | Read data valid strobe |
| rsp_rdata | output | DATA_W | Read data, unselected lanes zero |
| sram_addr | output | ADDR_W | Memory address |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lane_n | output | DATA_W/LANE_W | Byte lane enables, active low, bit 1 = upper byte |
| sram_dq_out | output | DATA_W | Data driven towards memory |
| sram_dq_oe | output | 1 | Tri-state enable for sram_dq_out |
| sram_dq_in | input | DATA_W | Data returned by memory |

## Verification
The properties assume that the host holds its request fields stable while req_valid is high and that the external memory returns data on sram_dq_in within the read window. The bench meets this by presenting each request at a falling edge, only in a cycle where req_ready is already high, and by dropping req_valid right after the accepting edge. The bench's memory model answers combinationally, driving the selected lanes from its array and a filler pattern on the other lanes. Masked-lane results are therefore visible at the ports.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_INIT  = 3'd0,
        ST_IDLE  = 3'd1,
        ST_READ  = 3'd2,
        ST_WRITE = 3'd3,
        ST_TURN  = 3'd4
    } ctrl_state_t;

endpackage

// File: rtl/sram_pwrup_timer.sv
module sram_pwrup_timer #(
    parameter int CYCLES = 15000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else if (!done) begin
            if (cnt_q == CW'(CYCLES - 1)) begin
                done <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             expired
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_decode.sv
module sram_lane_decode #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic [LANES-1:0]        mask,
    input  logic                    active,
    output logic [LANES-1:0]        en_n,
    output logic [LANES*LANE_W-1:0] bit_mask
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign en_n[g]                       = !(active && mask[g]);
        assign bit_mask[g*LANE_W +: LANE_W]  = {LANE_W{mask[g]}};
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
    parameter int ADDR_W       = 18,
    parameter int DATA_W       = 16,
    parameter int LANE_W       = 8,
    parameter int RD_CYCLES    = 2,
    parameter int WR_CYCLES    = 2,
    parameter int PWRUP_CYCLES = 15000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    input  logic                       req_write,
    input  logic [DATA_W/LANE_W-1:0]   req_mask,
    output logic                       rsp_valid,
    output logic [DATA_W-1:0]          rsp_rdata,
    output logic [ADDR_W-1:0]          sram_addr,
    output logic                       sram_cs_n,
    output logic                       sram_we_n,
    output logic                       sram_oe_n,
    output logic [DATA_W/LANE_W-1:0]   sram_lane_n,
    output logic [DATA_W-1:0]          sram_dq_out,
    output logic                       sram_dq_oe,
    input  logic [DATA_W-1:0]          sram_dq_in
);
    import sram_lane_pkg::*;

    localparam int LANES  = DATA_W / LANE_W;
    localparam int PH_MAX = (RD_CYCLES > WR_CYCLES) ? RD_CYCLES : WR_CYCLES;
    localparam int PH_W   = $clog2(PH_MAX + 1);

    ctrl_state_t state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rsp_q;

    logic              pw_done;
    logic              ph_expired;
    logic              accept;
    logic              null_req;
    logic              active;
    logic [PH_W-1:0]   ph_load_val;
    logic [DATA_W-1:0] lane_bits;

    assign accept      = req_valid && req_ready;
    assign null_req    = (req_mask == '0);
    assign ph_load_val = req_write ? PH_W'(WR_CYCLES - 1) : PH_W'(RD_CYCLES - 1);

    sram_pwrup_timer #(.CYCLES(PWRUP_CYCLES)) pwrup_i (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (pw_done)
    );

    sram_phase_timer #(.WIDTH(PH_W)) phase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (ph_load_val),
        .expired  (ph_expired)
    );

    sram_lane_decode #(.LANES(LANES), .LANE_W(LANE_W)) lanes_i (
        .mask     (mask_q),
        .active   (active),
        .en_n     (sram_lane_n),
        .bit_mask (lane_bits)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:  if (pw_done) state_d = ST_IDLE;
            ST_IDLE:  if (accept && !null_req) state_d = req_write ? ST_WRITE : ST_READ;
            ST_READ:  if (ph_expired) state_d = ST_IDLE;
            ST_WRITE: if (ph_expired) state_d = ST_TURN;
            ST_TURN:  state_d = ST_IDLE;
            default:  state_d = ST_INIT;
        endcase
    end

    // Request capture and read response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            rsp_q <= 1'b0;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_mask;
                if (null_req && !req_write) begin
                    rsp_q   <= 1'b1;
                    rdata_q <= '0;
                end
            end else if (state_q == ST_READ && ph_expired) begin
                rsp_q   <= 1'b1;
                rdata_q <= sram_dq_in & lane_bits;
            end
        end
    end

    // Output decode
    always_comb begin
        req_ready   = 1'b0;
        sram_cs_n   = 1'b1;
        sram_we_n   = 1'b1;
        sram_oe_n   = 1'b1;
        sram_dq_oe  = 1'b0;
        active      = 1'b0;
        unique case (state_q)
            ST_INIT:  ;
            ST_IDLE:  req_ready = 1'b1;
            ST_READ: begin
                sram_cs_n = 1'b0;
                sram_oe_n = 1'b0;
                active    = 1'b1;
            end
            ST_WRITE: begin
                sram_cs_n  = 1'b0;
                sram_we_n  = 1'b0;
                sram_dq_oe = 1'b1;
                active     = 1'b1;
            end
            ST_TURN:  ;
            default:  ;
        endcase
    end

    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;
    assign rsp_valid   = rsp_q;
    assign rsp_rdata   = rdata_q;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int ADDR_W       = 18,
    parameter int LANES        = 2,
    parameter int PWRUP_CYCLES = 15000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LANES-1:0]  req_mask,
    input logic              sram_cs_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_dq_oe,
    input logic [ADDR_W-1:0] sram_addr
);
    localparam int CW = $clog2(PWRUP_CYCLES + 1);

    logic [CW-1:0] boot_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_cnt <= '0;
        end else if (boot_cnt != CW'(PWRUP_CYCLES)) begin
            boot_cnt <= boot_cnt + 1'b1;
        end
    end

    // R1
    pwrup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_cnt < CW'(PWRUP_CYCLES)) |-> !req_ready);

    // R2
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_cs_n |-> (sram_we_n && sram_oe_n && !sram_dq_oe));

    // R3
    read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && sram_we_n) |-> !sram_oe_n);

    // R5
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (!sram_we_n && !sram_cs_n));

    // R7
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (!sram_dq_oe && $stable(sram_addr)));

    // R8
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n || sram_dq_oe) |-> sram_oe_n);

    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mask != '0) |=> !req_ready);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .ADDR_W       (ADDR_W),
    .LANES        (DATA_W / LANE_W),
    .PWRUP_CYCLES (PWRUP_CYCLES)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_mask   (req_mask),
    .sram_cs_n  (sram_cs_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_dq_oe (sram_dq_oe),
    .sram_addr  (sram_addr)
);

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;
    localparam int PWRUP = 15000;
    localparam int RDC   = 2;
    localparam int WRC   = 2;

    typedef struct packed {
        logic        wr;
        logic [1:0]  mask;
        logic [7:0]  addr;
        logic [15:0] wdata;
        logic [15:0] expd;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{1'b1, 2'b11, 8'h10, 16'hA1B2, 16'h0000},
        '{1'b0, 2'b11, 8'h10, 16'h0000, 16'hA1B2},
        '{1'b1, 2'b01, 8'h10, 16'h3344, 16'h0000},
        '{1'b0, 2'b11, 8'h10, 16'h0000, 16'hA144},
        '{1'b1, 2'b10, 8'h10, 16'h5566, 16'h0000},
        '{1'b0, 2'b11, 8'h10, 16'h0000, 16'h5544},
        '{1'b0, 2'b01, 8'h10, 16'h0000, 16'h0044},
        '{1'b0, 2'b10, 8'h10, 16'h0000, 16'h5500},
        '{1'b1, 2'b11, 8'h20, 16'hFFFF, 16'h0000},
        '{1'b1, 2'b00, 8'h20, 16'h0000, 16'h0000},
        '{1'b0, 2'b11, 8'h20, 16'h0000, 16'hFFFF},
        '{1'b0, 2'b00, 8'h20, 16'h0000, 16'h0000},
        '{1'b1, 2'b11, 8'hFF, 16'h1234, 16'h0000},
        '{1'b0, 2'b11, 8'hFF, 16'h0000, 16'h1234}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] sram_addr;
    logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [1:0]  sram_lane_n;
    logic [15:0] sram_dq_out;
    logic [15:0] sram_dq_in;

    int checks = 0;
    int fails  = 0;
    int contention_seen = 0;
    bit done_flag = 0;

    logic [15:0] mem [256];

    always #10 clk = ~clk;

    sram_lane_ctrl #(
        .RD_CYCLES(RDC), .WR_CYCLES(WRC), .PWRUP_CYCLES(PWRUP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_lane_n(sram_lane_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // Memory model: selected lanes answer, others carry a filler pattern
    always_comb begin
        sram_dq_in = 16'hEEEE;
        if (!sram_cs_n && sram_we_n && !sram_oe_n) begin
            if (!sram_lane_n[0]) sram_dq_in[7:0]  = mem[sram_addr[7:0]][7:0];
            if (!sram_lane_n[1]) sram_dq_in[15:8] = mem[sram_addr[7:0]][15:8];
        end
    end

    always @(posedge clk) begin
        if (!sram_cs_n && !sram_we_n && sram_dq_oe) begin
            if (!sram_lane_n[0]) mem[sram_addr[7:0]][7:0]  <= sram_dq_out[7:0];
            if (!sram_lane_n[1]) mem[sram_addr[7:0]][15:8] <= sram_dq_out[15:8];
        end
    end

    always @(negedge clk) begin
        if (rst_n && !sram_oe_n && (!sram_we_n || sram_dq_oe)) contention_seen++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Issue one request from a falling edge where req_ready is high
    task automatic do_req(input logic wr, input logic [1:0] mask,
                          input logic [7:0] addr, input logic [15:0] wdata,
                          input logic [15:0] expd);
        req_valid = 1'b1;
        req_write = wr;
        req_mask  = mask;
        req_addr  = {10'h0, addr};
        req_wdata = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        if (mask == 2'b00) begin
            // R9
            chk(req_ready && sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe
                && sram_lane_n == 2'b11, "R9 null strobes", {sram_cs_n, sram_lane_n, req_ready}, 4'hF);
            if (!wr) chk(rsp_valid && rsp_rdata == 16'h0, "R9 null read",
                         {rsp_valid, rsp_rdata}, 17'h10000);
        end else begin
            // R10
            chk(!req_ready, "R10 busy", req_ready, 0);
            if (wr) begin
                for (int i = 0; i < WRC; i++) begin
                    // R5 R4
                    chk(!sram_cs_n && !sram_we_n && sram_oe_n && sram_dq_oe
                        && sram_dq_out == wdata, "R5 write pulse",
                        {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, sram_dq_out},
                        {4'b0011, wdata});
                    chk(sram_lane_n == ~mask && sram_addr[7:0] == addr, "R4 write lanes",
                        {sram_lane_n, sram_addr[7:0]}, {~mask, addr});
                    @(negedge clk);
                end
                // R7
                chk(sram_we_n && sram_cs_n && !sram_dq_oe && !req_ready
                    && sram_addr[7:0] == addr, "R7 turnaround",
                    {sram_we_n, sram_cs_n, sram_dq_oe, req_ready}, 4'b1100);
                @(negedge clk);
                chk(req_ready, "R7 ready after turn", req_ready, 1);
            end else begin
                for (int i = 0; i < RDC; i++) begin
                    // R3 R4
                    chk(!sram_cs_n && sram_we_n && !sram_oe_n && !sram_dq_oe
                        && sram_addr[7:0] == addr, "R3 read strobes",
                        {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b0100);
                    chk(sram_lane_n == ~mask, "R4 read lanes", sram_lane_n, ~mask);
                    chk(!rsp_valid, "R3 no early response", rsp_valid, 0);
                    @(negedge clk);
                end
                chk(rsp_valid && rsp_rdata == expd, "R3 R4 R6 read data",
                    {rsp_valid, rsp_rdata}, {1'b1, expd});
                chk(req_ready, "R3 ready after read", req_ready, 1);
            end
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        finish_run();
    end

    initial begin
        int n;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        // R1 R2 reset state
        chk(!req_ready && sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe
            && sram_lane_n == 2'b11 && !rsp_valid, "R1 R2 reset state",
            {req_ready, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, sram_lane_n},
            7'b0111011);
        rst_n = 1'b1;
        repeat (PWRUP - 1) @(negedge clk);
        chk(!req_ready && sram_cs_n, "R1 hold during power-up", req_ready, 0);
        n = PWRUP - 1;
        while (!req_ready && n < PWRUP + 20) begin
            @(negedge clk);
            n++;
        end
        // R1
        chk(n == PWRUP + 1, "R1 power-up length", n, PWRUP + 1);

        foreach (VECS[k]) begin
            do_req(VECS[k].wr, VECS[k].mask, VECS[k].addr, VECS[k].wdata, VECS[k].expd);
        end

        // R6: lane isolation on a fresh word
        do_req(1'b1, 2'b11, 8'h40, 16'hC0DE, 16'h0);
        do_req(1'b1, 2'b10, 8'h40, 16'h77AA, 16'h0);
        do_req(1'b0, 2'b11, 8'h40, 16'h0, 16'h77DE);

        // R9: null write back-to-back with null read, memory unchanged
        do_req(1'b1, 2'b00, 8'h40, 16'h9999, 16'h0);
        do_req(1'b0, 2'b00, 8'h40, 16'h0, 16'h0);
        do_req(1'b0, 2'b11, 8'h40, 16'h0, 16'h77DE);

        // R10: request held while busy is accepted only once
        req_valid = 1'b1; req_write = 1'b0; req_mask = 2'b11;
        req_addr = 18'h40; req_wdata = 16'h0;
        n = 0;
        for (int c = 0; c < 2 * (RDC + 1); c++) begin
            @(negedge clk);
            if (rsp_valid) n++;
        end
        req_valid = 1'b0;
        repeat (RDC + 2) @(negedge clk);
        chk(n == 2 && req_ready, "R10 one accept per access", n, 2);

        // R8
        chk(contention_seen == 0, "R8 no output enable during write", contention_seen, 0);
        finish_run();
    end
endmodule